// File: doc/BRIEF.md
# SPI Command and Register Slave

This block is the host-facing SPI front end of an image sensor controller. The host lowers chip select and sends single-byte commands. The upper nibble of a command picks the operation and the lower nibble can carry a start address. Commands can start an image scan, apply a soft reset, return the status byte, return one pixel byte, run a register write burst or read one register. Start and soft reset act as soon as their byte arrives. They leave the design as single-cycle pulses.

Every byte the slave shifts out answers the byte the host sent just before it. A read sequence therefore ends with a dummy byte. The byte sent during a reply can be another command, so reads chain inside one chip-select frame. The register file drives the configuration outputs as plain bits. The pixel source sits outside the block and is stepped by a one-cycle read strobe. The SPI pins are sampled in the system clock domain through synchronizers, so SCK must run well below the system clock.

Top module: `sensor_spi_slave`

## Requirements
- R1: After the active-low hardware reset, register 8 (detection threshold) reads 0xFF and every other register reads 0x00. The SPI output is low and no pulse is issued.
- R2: SPI mode 0 is used. MOSI is sampled on the rising SCK edge. MISO shifts MSB first on the falling SCK edge, and the MSB of each reply is present before the first rising edge of its byte.
- R3: The reply to each byte is sent during the following byte. The first byte of every frame returns 0x00.
- R4: Command 0x4N writes each following byte of the frame to register N, N+1, and so on. Bytes aimed past the last register (index NREGS-1) are dropped, and each of these bytes returns 0x00.
- R5: Command 0x5N returns register N (0x00 if N >= NREGS). Reads chain inside one frame.
- R6: Command 0x03 returns the 8-bit status input, with bit 0 meaning image ready and bit 6 meaning finger detected.
- R7: Command 0x01 returns the current pixel byte and pulses the pixel read strobe for exactly one cycle. Repeated commands return successive pixels.
- R8: Command 0x02 issues a one-cycle start pulse per command, with no data bytes.
- R9: Command 0x04 issues a one-cycle soft-reset pulse and restores all registers to their R1 values. Command decoding in the same frame carries on unaffected.
- R10: Any other command code changes no register, issues no pulse and returns 0x00.
- R11: A rising chip select ends the frame and discards a partly received byte. The next frame's first byte is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| spi_sck | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| status_flags | input | 8 | Status byte returned by command 0x03 |
| pix_data | input | 8 | Current pixel byte from the image source |
| pix_rd | output | 1 | One-cycle strobe: pixel consumed |
| start_pulse | output | 1 | One-cycle image scan start |
| srst_pulse | output | 1 | One-cycle soft reset to the datapath |
| cfg_regs | output | NREGS*8 | Register file contents, register i at bits [8i+7:8i] |

## Verification
The bench targets the one-byte lag between command and reply. A design that answered in the same byte, or that did not clear the reply at the start of a frame, would shift every returned byte by one position. Write bursts that start near the top of the file check address saturation: a design that wrapped the pointer would corrupt register 0. A frame cut off after three bits is followed by a write. A bit counter that was not cleared would misalign that write, and the readback would show it. A soft reset is followed by reads in the same frame. A design that also reset its command logic would return zeros where the threshold value 0xFF is expected.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] OP_PIXEL  = 8'h01;
  localparam logic [7:0] OP_START  = 8'h02;
  localparam logic [7:0] OP_STATUS = 8'h03;
  localparam logic [7:0] OP_SRST   = 8'h04;
  localparam logic [3:0] GRP_WRITE = 4'h4;
  localparam logic [3:0] GRP_READ  = 4'h5;

  typedef enum logic [2:0] {
    K_NONE, K_PIXEL, K_START, K_STATUS, K_SRST, K_WRITE, K_READ
  } cmd_kind_t;

  function automatic cmd_kind_t classify(input logic [7:0] b);
    if (b == OP_PIXEL)              return K_PIXEL;
    else if (b == OP_START)         return K_START;
    else if (b == OP_STATUS)        return K_STATUS;
    else if (b == OP_SRST)          return K_SRST;
    else if (b[7:4] == GRP_WRITE)   return K_WRITE;
    else if (b[7:4] == GRP_READ)    return K_READ;
    else                            return K_NONE;
  endfunction

  function automatic logic [3:0] start_addr(input logic [7:0] b);
    return b[3:0];
  endfunction

  function automatic logic [7:0] reset_value(input int idx, input int thr_idx);
    return (idx == thr_idx) ? 8'hFF : 8'h00;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i]; s2 <= RST_VAL[i]; prev <= RST_VAL[i];
      end else begin
        s1 <= pin_in[i]; s2 <= s1; prev <= s2;
      end
    end
    assign level[i] = s2;
    assign rise[i]  = s2 & ~prev;
    assign fall[i]  = ~s2 & prev;
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            frame_active,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic            mosi_bit,
  input  logic            load_en,
  input  logic [BITS-1:0] load_byte,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte,
  output logic            miso
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [BITS-1:0] rx_sh, tx_sh, byte_q;
  logic [CW-1:0]   cnt;
  logic            done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh <= '0; tx_sh <= '0; byte_q <= '0; cnt <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (frame_start) begin
        cnt <= '0; rx_sh <= '0; tx_sh <= '0;
      end else if (!frame_active) begin
        cnt <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh <= {rx_sh[BITS-2:0], mosi_bit};
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) begin
            done_q <= 1'b1;
            byte_q <= {rx_sh[BITS-2:0], mosi_bit};
          end
        end
        if (load_en)
          tx_sh <= load_byte;
        else if (sck_fall && cnt != '0)
          tx_sh <= {tx_sh[BITS-2:0], 1'b0};
      end
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = byte_q;
  assign miso      = tx_sh[BITS-1];

  assert_frame_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (tx_sh == '0 && cnt == '0));
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !frame_start && !sck_fall && !load_en) |=> $stable(tx_sh));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cmd_pkg::*;
#(
  parameter int NREGS   = 17,
  parameter int THR_IDX = 8,
  parameter int AW      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [3:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [NREGS*8-1:0] regs_flat
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam logic [7:0] RV = reset_value(i, THR_IDX);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= RV;
      else if (srst)                             q <= RV;
      else if (wr_en && wr_addr == AW'(i))       q <= wr_data;
    end
    assign regs_flat[i*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREGS; i++)
      if (32'(rd_addr) == i) rd_data = regs_flat[i*8 +: 8];
  end

  assert_drop_past_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !srst && 32'(wr_addr) >= NREGS) |=> $stable(regs_flat));
  assert_srst_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (regs_flat[THR_IDX*8 +: 8] == 8'hFF));
endmodule

// File: rtl/sensor_spi_slave.sv
module sensor_spi_slave
  import spi_cmd_pkg::*;
#(
  parameter int NREGS   = 17,
  parameter int THR_IDX = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  input  logic [7:0]         status_flags,
  input  logic [7:0]         pix_data,
  output logic               pix_rd,
  output logic               start_pulse,
  output logic               srst_pulse,
  output logic [NREGS*8-1:0] cfg_regs
);
  localparam int AW_MIN = $clog2(NREGS + 1);
  localparam int AW     = (AW_MIN > 4) ? AW_MIN : 4;

  logic [2:0] pin_lvl, pin_rise, pin_fall;
  spi_pin_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_in({spi_cs_n, spi_sck, spi_mosi}),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  logic frame_active, frame_start, sck_rise, sck_fall, mosi_bit;
  assign frame_active = ~pin_lvl[2];
  assign frame_start  = pin_fall[2];
  assign sck_rise     = pin_rise[1];
  assign sck_fall     = pin_fall[1];
  assign mosi_bit     = pin_lvl[0];

  logic       byte_done, load_en;
  logic [7:0] rx_byte, load_byte;

  spi_byte_shift #(.BITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_active(frame_active),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_bit(mosi_bit),
    .load_en(load_en), .load_byte(load_byte),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  logic          in_write_q;
  logic [AW-1:0] ptr_q;
  logic          wr_en;
  logic [7:0]    rd_data;
  cmd_kind_t     kind;

  spi_reg_bank #(.NREGS(NREGS), .THR_IDX(THR_IDX), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .srst(srst_pulse),
    .wr_en(wr_en), .wr_addr(ptr_q), .wr_data(rx_byte),
    .rd_addr(start_addr(rx_byte)), .rd_data(rd_data),
    .regs_flat(cfg_regs)
  );

  assign kind    = classify(rx_byte);
  assign load_en = byte_done;

  always_comb begin
    load_byte   = 8'h00;
    wr_en       = 1'b0;
    pix_rd      = 1'b0;
    start_pulse = 1'b0;
    srst_pulse  = 1'b0;
    if (byte_done) begin
      if (in_write_q) begin
        wr_en = 1'b1;
      end else begin
        case (kind)
          K_PIXEL:  begin load_byte = pix_data; pix_rd = 1'b1; end
          K_START:  start_pulse = 1'b1;
          K_STATUS: load_byte = status_flags;
          K_SRST:   srst_pulse = 1'b1;
          K_READ:   load_byte = rd_data;
          default:  load_byte = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_write_q <= 1'b0;
      ptr_q      <= '0;
    end else if (frame_start) begin
      in_write_q <= 1'b0;
      ptr_q      <= '0;
    end else if (byte_done) begin
      if (in_write_q) begin
        if (32'(ptr_q) < NREGS) ptr_q <= ptr_q + 1'b1;
      end else if (kind == K_WRITE) begin
        in_write_q <= 1'b1;
        ptr_q      <= AW'(start_addr(rx_byte));
      end
    end
  end

  assert_frame_exit_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !in_write_q);
  assert_pix_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd |=> !pix_rd);
  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pix_rd, start_pulse, srst_pulse, wr_en}) <= 1);
endmodule

// File: tb/tb_sensor_spi_slave.sv
module tb_sensor_spi_slave;
  localparam int NREGS = 17;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, pix_rd, start_pulse, srst_pulse;
  logic [7:0] status_flags = 8'h00;
  logic [7:0] pix_data;
  logic [NREGS*8-1:0] cfg_regs;

  sensor_spi_slave #(.NREGS(NREGS), .THR_IDX(8)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .status_flags(status_flags), .pix_data(pix_data),
    .pix_rd(pix_rd), .start_pulse(start_pulse), .srst_pulse(srst_pulse),
    .cfg_regs(cfg_regs)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  function automatic logic [7:0] pix_val(input int idx);
    return 8'((idx * 37 + 11) & 255);
  endfunction

  int pix_idx = 0, start_cnt = 0, srst_cnt = 0;
  logic start_prev = 1'b0, srst_prev = 1'b0, pix_prev = 1'b0;
  assign pix_data = pix_val(pix_idx);
  always @(posedge clk) begin
    if (pix_rd) pix_idx <= pix_idx + 1;
    if (start_pulse) start_cnt <= start_cnt + 1;
    if (srst_pulse) srst_cnt <= srst_cnt + 1;
    start_prev <= start_pulse; srst_prev <= srst_pulse; pix_prev <= pix_rd;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock width checks on the pulses (R7, R8, R9)
  always @(negedge clk) if (rst_n) begin
    if (start_pulse && start_prev) chk("R8 start width", 2, 1);
    if (srst_pulse && srst_prev)   chk("R9 srst width", 2, 1);
    if (pix_rd && pix_prev)        chk("R7 pix_rd width", 2, 1);
  end

  // behavioural reference model
  int mreg[NREGS];
  int mpix = 0, mstart = 0, msrst = 0;
  logic [7:0] gexp[$];
  string gtag[$];

  task automatic model_reset();
    for (int i = 0; i < NREGS; i++) mreg[i] = (i == 8) ? 255 : 0;
  endtask

  task automatic model_run(input logic [7:0] q[$]);
    logic [7:0] resp = 8'h00;
    string rtag = "R3";
    bit inw = 0;
    int ptr = 0;
    gexp.delete(); gtag.delete();
    foreach (q[i]) begin
      logic [7:0] b = q[i];
      gexp.push_back(resp); gtag.push_back(rtag);
      resp = 8'h00;
      if (inw) begin
        if (ptr < NREGS) mreg[ptr] = b;
        ptr++; rtag = "R4";
      end else if (b == 8'h01) begin resp = pix_val(mpix); mpix++; rtag = "R7"; end
      else if (b == 8'h02) begin mstart++; rtag = "R8"; end
      else if (b == 8'h03) begin resp = status_flags; rtag = "R6"; end
      else if (b == 8'h04) begin model_reset(); msrst++; rtag = "R9"; end
      else if (b[7:4] == 4'h4) begin inw = 1; ptr = b[3:0]; rtag = "R4"; end
      else if (b[7:4] == 4'h5) begin
        resp = (b[3:0] < NREGS) ? 8'(mreg[b[3:0]]) : 8'h00; rtag = "R5";
      end else rtag = "R10";
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic compare_state(input string tag);
    for (int i = 0; i < NREGS; i++)
      chk($sformatf("%s reg%0d", tag, i), cfg_regs[i*8 +: 8], mreg[i]);
    chk("R8 start count", start_cnt, mstart);
    chk("R9 srst count", srst_cnt, msrst);
    chk("R7 pixel count", pix_idx, mpix);
  endtask

  task automatic frame(input logic [7:0] q[$], input string tag);
    logic [7:0] rx;
    model_run(q);
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    foreach (q[i]) begin
      spi_byte(q[i], rx);
      chk($sformatf("R2/%s/%s byte%0d", gtag[i], tag, i), rx, gexp[i]);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    compare_state(tag);
  endtask

  task automatic partial_abort();
    logic [7:0] junk;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    junk = 8'hFF;
    for (int b = 0; b < 3; b++) begin
      mosi = junk[b];
      repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    repeat (HALF) @(negedge clk); cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk("R1 miso", miso, 0);
    compare_state("R1");

    // R4 full burst from address 0
    q = {8'h40};
    for (int i = 0; i < NREGS; i++) q.push_back(8'(i * 11 + 5));
    frame(q, "R4 burst");
    // R5 chained reads with dummy tail
    frame('{8'h53, 8'h58, 8'h50, 8'h5F, 8'h00}, "R5 chain");
    // R6 status
    status_flags = 8'h41;
    frame('{8'h03, 8'h03, 8'h00}, "R6 status41");
    status_flags = 8'h80;
    frame('{8'h03, 8'h00}, "R6 status80");
    // R7 pixel stream
    q = {};
    for (int i = 0; i < 20; i++) q.push_back(8'h01);
    q.push_back(8'h00);
    frame(q, "R7 pixels");
    // R8 start pulses
    frame('{8'h02, 8'h02, 8'h00}, "R8 start");
    // R10 unknown codes
    frame('{8'h77, 8'hA5, 8'h3C, 8'hFF, 8'h00}, "R10 unknown");
    // R4 write near top, excess dropped
    frame('{8'h4E, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, "R4 top");
    frame('{8'h5E, 8'h5F, 8'h50, 8'h00}, "R4 readback");
    // R9 soft reset then reads in the same frame
    frame('{8'h04, 8'h58, 8'h51, 8'h00}, "R9 srst");
    // R11 partial byte then fresh command
    partial_abort();
    frame('{8'h41, 8'hAA}, "R11 write");
    frame('{8'h51, 8'h00}, "R11 read");
    // R11 write mode does not survive a frame boundary
    frame('{8'h46, 8'h12}, "R11 w6");
    frame('{8'h56, 8'h55, 8'h00}, "R11 newcmd");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule